// File: doc/BRIEF.md
# Signed Integer Cube-Root Unit with Request/Acknowledge Handshake

The block takes a 24-bit two's complement operand and returns its real cube root, truncated toward zero, as a 9-bit two's complement value. A client hands over work through a return-to-zero handshake. It places the operand on `din` and raises `req`. The unit then computes and presents the answer on `dout` together with `ack`. It keeps both until the client withdraws `req`, and only then drops `ack` and becomes ready for the next operand.

Internally a small controller steps a sequential datapath. The datapath captures the operand's sign and unsigned magnitude on acceptance. It then decides the eight root bits one at a time, from the most significant down. For each bit it cubes a candidate with two multipliers and compares the cube against the magnitude. A final step restores the sign. Reset is synchronous and active-high, and may arrive at any point in a transaction.

Top module: `cbrt_hs_unit`

## Requirements
- R1: When `ack` is 1, the magnitude of `dout` equals the largest integer r with r*r*r no greater than the magnitude of the accepted operand. This holds over the full input range, so 8388607 gives 203 and 4194303 gives 161.
- R2: A negative operand yields the two's complement negation of its magnitude's root, so -8388608 gives -203 and -4194303 gives -161. An operand of 0 gives 0.
- R3: When idle, the unit accepts an operand at the first rising edge at which `req` is 1. `ack` then becomes 1 at the tenth rising edge, counting the accepting edge as the first.
- R4: While `ack` is 1, `dout` does not change. `ack` stays 1 for as long as `req` is sampled 1.
- R5: `ack` falls at the first rising edge at which `req` is sampled 0 while `ack` is 1. A new operand is accepted no earlier than the following edge.
- R6: At any rising edge with `rst` = 1, the unit abandons any transaction. After that edge `ack` is 0, `dout` is 0 and the unit is idle.
- R7: `din` is sampled only at the accepting edge. Changes on `din` after that edge have no effect on the result presented with `ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Client request, held until the result is read |
| din | input | 24 | Operand, two's complement |
| ack | output | 1 | Result valid; returns to 0 after `req` falls |
| dout | output | 9 | Cube root truncated toward zero, two's complement |

## Verification
The hardest situation to reach from the ports is a reset that lands partway through the bit-by-bit search, or while `ack` is held high. In that case the abandoned transaction must leave no trace in the next one. The stimulus raises `req`, lets a chosen number of cycles pass, and asserts `rst` with `req` withdrawn. It then runs a fresh transaction with a different operand and compares every cycle against the reference timeline. A second awkward case is an operand that changes after acceptance. The bench drives a new `din` mid-computation and expects the answer for the original one.

// File: rtl/cbrt_pkg.sv
package cbrt_pkg;

  // Controller phases of one transaction
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CALC = 2'd1,
    ST_SIGN = 2'd2,
    ST_DONE = 2'd3
  } cbrt_state_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cbrt_ctrl.sv
module cbrt_ctrl
  import cbrt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic last_bit,
  output logic load,
  output logic step,
  output logic fin,
  output logic ack
);

  cbrt_state_t state_q;
  cbrt_state_t state_d;

  // Next-state decision
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req)      state_d = ST_CALC;
      ST_CALC: if (last_bit) state_d = ST_SIGN;
      ST_SIGN:               state_d = ST_DONE;
      ST_DONE: if (!req)     state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  // State register with synchronous reset
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign load = (state_q == ST_IDLE) && req;
  assign step = (state_q == ST_CALC);
  assign fin  = (state_q == ST_SIGN);
  assign ack  = (state_q == ST_DONE);

endmodule

// File: rtl/cbrt_root_iter.sv
module cbrt_root_iter
  import cbrt_pkg::*;
#(
  parameter int unsigned IN_W   = 24,
  parameter int unsigned ROOT_W = 8
) (
  input  logic              clk,
  input  logic              load,
  input  logic              step,
  input  logic [IN_W-1:0]   din,
  output logic [ROOT_W-1:0] root,
  output logic              neg,
  output logic              last_bit
);

  localparam int unsigned IDX_W  = (ROOT_W > 1) ? $clog2(ROOT_W) : 1;
  localparam int unsigned CUBE_W = 3 * ROOT_W;
  localparam int unsigned CMP_W  = max_u(CUBE_W, IN_W);

  logic [IN_W-1:0]   mag_q;
  logic              neg_q;
  logic [ROOT_W-1:0] root_q;
  logic [IDX_W-1:0]  idx_q;

  logic [IN_W-1:0]   mag_in;
  logic [ROOT_W-1:0] bit_mask;
  logic [ROOT_W-1:0] trial;
  logic [CMP_W-1:0]  trial_x;
  logic [CMP_W-1:0]  trial_sq;
  logic [CMP_W-1:0]  trial_cube;
  logic              fits;

  // Unsigned magnitude; the most negative operand maps to 2**(IN_W-1)
  assign mag_in = din[IN_W-1] ? (~din + IN_W'(1)) : din;

  // One-hot selector of the bit under trial
  for (genvar g = 0; g < ROOT_W; g++) begin : g_mask
    assign bit_mask[g] = (idx_q == IDX_W'(g));
  end

  assign trial      = root_q | bit_mask;
  assign trial_x    = CMP_W'(trial);
  assign trial_sq   = trial_x * trial_x;
  assign trial_cube = trial_sq * trial_x;
  assign fits       = (trial_cube <= CMP_W'(mag_q));

  // Operand capture and bit-serial search, clock enables written out
  always_ff @(posedge clk) begin
    if (load) begin
      mag_q  <= mag_in;
      neg_q  <= din[IN_W-1];
      root_q <= '0;
      idx_q  <= IDX_W'(ROOT_W - 1);
    end else if (step) begin
      if (fits) begin
        root_q <= trial;
      end
      idx_q <= idx_q - IDX_W'(1);
    end
  end

  assign root     = root_q;
  assign neg      = neg_q;
  assign last_bit = (idx_q == '0);

endmodule

// File: rtl/cbrt_sign_fix.sv
module cbrt_sign_fix #(
  parameter int unsigned ROOT_W = 8,
  parameter int unsigned OUT_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  logic [ROOT_W-1:0] root,
  input  logic              neg,
  output logic [OUT_W-1:0]  dout
);

  logic [OUT_W-1:0] root_ext;
  logic [OUT_W-1:0] signed_res;
  logic [OUT_W-1:0] dout_q;

  assign root_ext   = OUT_W'(root);
  assign signed_res = neg ? (OUT_W'(0) - root_ext) : root_ext;

  // Result register: written once per transaction, held otherwise
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
    end else if (fin) begin
      dout_q <= signed_res;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/cbrt_hs_unit.sv
module cbrt_hs_unit #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IN_W-1:0]  din,
  output logic             ack,
  output logic [OUT_W-1:0] dout
);

  localparam int unsigned ROOT_W = OUT_W - 1;

  logic              load;
  logic              step;
  logic              fin;
  logic              last_bit;
  logic [ROOT_W-1:0] root;
  logic              neg;

  cbrt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .last_bit (last_bit),
    .load     (load),
    .step     (step),
    .fin      (fin),
    .ack      (ack)
  );

  cbrt_root_iter #(
    .IN_W   (IN_W),
    .ROOT_W (ROOT_W)
  ) u_iter (
    .clk      (clk),
    .load     (load),
    .step     (step),
    .din      (din),
    .root     (root),
    .neg      (neg),
    .last_bit (last_bit)
  );

  cbrt_sign_fix #(
    .ROOT_W (ROOT_W),
    .OUT_W  (OUT_W)
  ) u_sign (
    .clk  (clk),
    .rst  (rst),
    .fin  (fin),
    .root (root),
    .neg  (neg),
    .dout (dout)
  );

endmodule

// File: rtl/cbrt_hs_checker.sv
module cbrt_hs_checker #(
  parameter int unsigned OUT_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             req,
  input logic             ack,
  input logic [OUT_W-1:0] dout
);

  AST_ACK_LOW_AFTER_RST: assert property (@(posedge clk)
    $past(rst) |-> (!ack && dout == '0)); // R6

  AST_DOUT_HELD: assert property (@(posedge clk) disable iff (rst)
    ack |=> (!ack || $stable(dout))); // R4

  AST_ACK_HELD: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack); // R4

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ack && !req) |=> !ack); // R5

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(req)); // R3

endmodule

bind cbrt_hs_unit cbrt_hs_checker #(.OUT_W(OUT_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .req  (req),
  .ack  (ack),
  .dout (dout)
);

// File: tb/cbrt_hs_unit_bench.sv
`timescale 1ns/1ps
module cbrt_hs_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [23:0] din = '0;
  logic        ack;
  logic [8:0]  dout;

  int n_cmp  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit started = 1'b0;

  // reference timeline
  bit              m_busy = 0;
  bit              m_ack  = 0;
  int              m_cnt  = 0;
  logic signed [8:0] m_dout = '0;
  logic signed [8:0] m_res  = '0;

  cbrt_hs_unit u_cbrt_hs_unit (
    .clk (clk), .rst (rst), .req (req), .din (din), .ack (ack), .dout (dout)
  );

  always #2.5 clk = ~clk;

  function automatic int ref_root(input int v);
    int m = (v < 0) ? -v : v;
    int r = 0;
    while ((r + 1) * (r + 1) * (r + 1) <= m) r++;
    return (v < 0) ? -r : r;
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: handshake timeline from R3, R5, R6, R7
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      started = 1'b1;
      m_busy = 0; m_ack = 0; m_cnt = 0; m_dout = '0;
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == 10) begin
        m_busy = 0; m_ack = 1; m_dout = m_res;
      end
    end else if (m_ack) begin
      if (!req) m_ack = 0;
    end else if (req) begin
      m_busy = 1; m_cnt = 1;
      m_res = 9'(ref_root(int'($signed(din))));
    end
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
      finish_run();
    end
  end

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started) begin
      check("R3 ack timeline", int'(ack), int'(m_ack));
      check("R1 dout timeline", int'($signed(dout)), int'(m_dout));
    end
  end

  task automatic run_op(input int v, input int hold);
    @(negedge clk);
    din = 24'(v);
    req = 1'b1;
    do @(negedge clk); while (!ack);
    check(v < 0 ? "R2 negative root" : "R1 root", int'($signed(dout)), ref_root(v));
    repeat (hold) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    check("R5 ack released", int'(ack), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R6 reset ack", int'(ack), 0);
    check("R6 reset dout", int'(dout), 0);

    run_op(0, 0);
    run_op(1, 0);
    run_op(-1, 0);
    run_op(7, 0);
    run_op(-7, 0);
    run_op(8, 0);
    run_op(-8, 0);
    run_op(26, 1);
    run_op(27, 0);
    run_op(-27, 0);
    run_op(4194303, 0);
    run_op(-4194303, 0);
    run_op(8388607, 0);
    run_op(-8388608, 0);
    run_op(8242407, 0);
    run_op(8242408, 0);
    run_op(8365427, 0);
    run_op(-8365426, 0);
    run_op(999999, 0);
    run_op(1000000, 5); // R4: req held long after ack

    for (int i = 0; i < 40; i++) begin
      int v = int'($signed(24'($urandom)));
      run_op(v, i % 3);
    end

    // R7: operand changed after acceptance
    @(negedge clk);
    din = 24'(1000); req = 1'b1;
    repeat (2) @(negedge clk);
    din = 24'(-5000000);
    do @(negedge clk); while (!ack);
    check("R7 latched operand", int'($signed(dout)), 10);
    req = 1'b0;
    repeat (2) @(negedge clk);

    // R6: reset during the search
    for (int k = 1; k < 12; k += 4) begin
      @(negedge clk);
      din = 24'(-3375); req = 1'b1;
      repeat (k) @(negedge clk);
      rst = 1'b1; req = 1'b0;
      @(negedge clk);
      rst = 1'b0;
      check("R6 mid reset ack", int'(ack), 0);
      check("R6 mid reset dout", int'(dout), 0);
      run_op(64, 0);
    end

    // R6: reset while ack is high
    @(negedge clk);
    din = 24'(125); req = 1'b1;
    do @(negedge clk); while (!ack);
    rst = 1'b1; req = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R6 reset in done", int'(ack), 0);
    run_op(-216, 0);

    // R5: back-to-back request right after release
    @(negedge clk);
    din = 24'(343); req = 1'b1;
    do @(negedge clk); while (!ack);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; din = 24'(-512);
    do @(negedge clk); while (!ack);
    check("R5 next op", int'($signed(dout)), -8);
    req = 1'b0;
    repeat (3) @(negedge clk);

    finish_run();
  end

endmodule